// File: doc/BRIEF.md
# Triple-Error Locator and Chien Corrector for a (15,5) Cyclic Code

This block finishes the correction of a 15-bit word of the (15,5) binary triple-error-correcting cyclic code over GF(16). The field uses the primitive polynomial x^4 + x + 1, so alpha is 4'b0010. An upstream stage supplies three odd-indexed syndromes, S1 = r(alpha), S3 = r(alpha^3) and S5 = r(alpha^5). It also supplies the received word, where bit j holds the coefficient of x^j. A one-cycle start pulse hands all of these over together.

The block captures its inputs and then finds the error-locator polynomial sigma(x) = 1 + s1·x + s2·x^2 + s3·x^3 from closed-form expressions:
- s1 = S1
- s2 = (S1^2·S3 + S5) divided by (S1^3 + S3), using a field inverse
- s3 = S1^3 + S3 + S1·s2

When the divisor is zero, s2 is taken as zero. That keeps the zero-error and single-error cases free of a division by zero.

A Chien search then visits alpha^0 through alpha^14, one element per clock. A root at alpha^l marks bit (15 − l) mod 15 as wrong. The marked bits form an error mask, which is XORed onto the captured word. The corrected word and the mask are registered, and a done pulse announces them.

Top module: `bch3_corrector`

## Requirements
- R1: While reset is high and on the first cycle after it, done_o is 0 and corr_word_o and err_mask_o are all zeros.
- R2: A start pulse is acted on only when the block is idle. A start that arrives during a decode changes neither the result nor the timing of that decode.
- R3: When the received word is a codeword (all three syndromes zero), err_mask_o is zero and corr_word_o equals the received word.
- R4: A single flipped bit anywhere in the 15 positions is corrected. This path uses s2 = 0, because S1^3 + S3 = 0.
- R5: Any two flipped bits are corrected, and the original codeword is recovered exactly.
- R6: Any three flipped bits are corrected, and the original codeword is recovered exactly.
- R7: err_mask_o bit j is 1 exactly when received bit j (the coefficient of x^j) was found in error.
- R8: done_o is a pulse one cycle long. It rises on the 17th rising edge after the edge that samples start.
- R9: When done_o is high, corr_word_o XOR err_mask_o equals the captured received word, and err_mask_o has at most three ones.
- R10: corr_word_o and err_mask_o change only on the cycle in which done_o goes high. They hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request that captures the syndromes and the word |
| syn1_i | input | 4 | Syndrome S1 = r(alpha) |
| syn3_i | input | 4 | Syndrome S3 = r(alpha^3) |
| syn5_i | input | 4 | Syndrome S5 = r(alpha^5) |
| rx_word_i | input | 15 | Received word; bit j is the coefficient of x^j |
| corr_word_o | output | 15 | Corrected word (registered) |
| err_mask_o | output | 15 | Positions found in error (registered) |
| done_o | output | 1 | One-cycle pulse marking new outputs |

## Verification
Four properties are checked on every cycle:
- done is a single-cycle pulse;
- the outputs hold their values between pulses;
- corrected word XOR mask gives back the captured word;
- the mask weight never exceeds three, since a cubic has at most three roots.

Only the bench's scenarios can show that the mask is the right one. The bench covers every pattern of weight 0 and 1 on all 32 codewords, and every pattern of weight 2 and 3 on several codewords, with syndromes computed in the bench from a table of alpha powers. It also measures the latency of each decode and shows that a start pulse arriving during a decode is ignored.

// File: rtl/bch3_pkg.sv
`timescale 1ns/1ps
package bch3_pkg;
  parameter int GF_M = 4;
  localparam int GF_N = (1 << GF_M) - 1;
  parameter logic [GF_M:0] GF_POLY = 5'b10011;

  typedef logic [GF_M-1:0] gf_t;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SRCH, ST_FIN} st_e;

  // Shift-and-add product reduced by the field polynomial.
  function automatic gf_t gf_mul(input gf_t a, input gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh  = a;
    for (int i = 0; i < GF_M; i++) begin
      if (b[i]) acc = acc ^ sh;
      if (sh[GF_M-1]) sh = (sh << 1) ^ GF_POLY[GF_M-1:0];
      else            sh = sh << 1;
    end
    return acc;
  endfunction

  // a^(2^M - 2) is the inverse; zero maps to zero.
  function automatic gf_t gf_inv(input gf_t a);
    gf_t r;
    r = gf_t'(1);
    for (int i = 0; i < GF_N - 1; i++) r = gf_mul(r, a);
    return r;
  endfunction

  function automatic gf_t gf_alpha_pow(input int k);
    gf_t r;
    r = gf_t'(1);
    for (int i = 0; i < k; i++) r = gf_mul(r, gf_t'(2));
    return r;
  endfunction
endpackage

// File: rtl/bch3_locator.sv
`timescale 1ns/1ps
module bch3_locator
  import bch3_pkg::*;
(
  input  gf_t s1_i,
  input  gf_t s3_i,
  input  gf_t s5_i,
  output gf_t sig1_o,
  output gf_t sig2_o,
  output gf_t sig3_o
);
  gf_t s1_sq, s1_cu, denom, numer, sig2;

  always_comb begin
    s1_sq  = gf_mul(s1_i, s1_i);
    s1_cu  = gf_mul(s1_sq, s1_i);
    denom  = s1_cu ^ s3_i;
    numer  = gf_mul(s1_sq, s3_i) ^ s5_i;
    sig2   = (denom == '0) ? '0 : gf_mul(numer, gf_inv(denom));
    sig1_o = s1_i;
    sig2_o = sig2;
    sig3_o = denom ^ gf_mul(s1_i, sig2);
  end
endmodule

// File: rtl/bch3_chien_term.sv
`timescale 1ns/1ps
module bch3_chien_term
  import bch3_pkg::*;
#(
  parameter int POWER = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic step,
  input  gf_t  seed,
  output gf_t  term
);
  localparam gf_t STEP_K = gf_alpha_pow(POWER);

  always_ff @(posedge clk) begin
    if (rst)       term <= '0;
    else if (load) term <= seed;
    else if (step) term <= gf_mul(term, STEP_K);
  end
endmodule

// File: rtl/bch3_corrector.sv
`timescale 1ns/1ps
module bch3_corrector
  import bch3_pkg::*;
#(
  parameter int M = GF_M,
  parameter int N = GF_N
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [M-1:0] syn1_i,
  input  logic [M-1:0] syn3_i,
  input  logic [M-1:0] syn5_i,
  input  logic [N-1:0] rx_word_i,
  output logic [N-1:0] corr_word_o,
  output logic [N-1:0] err_mask_o,
  output logic         done_o
);
  localparam int NT = 3;
  localparam int IDXW = $clog2(N + 1);
  localparam logic [IDXW-1:0] N_L = IDXW'(N);
  localparam logic [IDXW-1:0] LAST = IDXW'(N - 1);

  st_e            state;
  gf_t            s1_q, s3_q, s5_q;
  logic [N-1:0]   rx_q, mask_q;
  logic [IDXW-1:0] step_q, pos;
  gf_t            sig [1:NT];
  gf_t            term [1:NT];
  logic           load, step, is_root;

  bch3_locator u_loc (
    .s1_i(s1_q), .s3_i(s3_q), .s5_i(s5_q),
    .sig1_o(sig[1]), .sig2_o(sig[2]), .sig3_o(sig[3])
  );

  assign load = (state == ST_LOAD);
  assign step = (state == ST_SRCH);

  for (genvar g = 1; g <= NT; g++) begin : g_term
    bch3_chien_term #(.POWER(g)) u_term (
      .clk(clk), .rst(rst), .load(load), .step(step),
      .seed(sig[g]), .term(term[g])
    );
  end

  always_comb begin
    gf_t acc;
    acc = gf_t'(1);
    for (int i = 1; i <= NT; i++) acc = acc ^ term[i];
    is_root = (acc == '0);
    pos = (step_q == '0) ? '0 : (N_L - step_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      s1_q        <= '0;
      s3_q        <= '0;
      s5_q        <= '0;
      rx_q        <= '0;
      mask_q      <= '0;
      step_q      <= '0;
      corr_word_o <= '0;
      err_mask_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          s1_q   <= syn1_i;
          s3_q   <= syn3_i;
          s5_q   <= syn5_i;
          rx_q   <= rx_word_i;
          mask_q <= '0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          step_q <= '0;
          state  <= ST_SRCH;
        end
        ST_SRCH: begin
          if (is_root) mask_q[pos] <= 1'b1;
          if (step_q == LAST) state <= ST_FIN;
          else                step_q <= step_q + 1'b1;
        end
        ST_FIN: begin
          corr_word_o <= rx_q ^ mask_q;
          err_mask_o  <= mask_q;
          done_o      <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bch3_corrector_chk.sv
`timescale 1ns/1ps
module bch3_corrector_chk #(
  parameter int N = 15
) (
  input logic         clk,
  input logic         rst,
  input logic         done_o,
  input logic [N-1:0] corr_word_o,
  input logic [N-1:0] err_mask_o,
  input logic [N-1:0] rx_q
);
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done_o && corr_word_o == '0 && err_mask_o == '0));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_xor_relation_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ((corr_word_o ^ err_mask_o) == rx_q));

  assert_mask_weight_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($countones(err_mask_o) <= 3));

  assert_output_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> ($stable(corr_word_o) && $stable(err_mask_o)));
endmodule

bind bch3_corrector bch3_corrector_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .done_o(done_o),
  .corr_word_o(corr_word_o), .err_mask_o(err_mask_o), .rx_q(rx_q)
);

// File: tb/sim_bch3_corrector.sv
`timescale 1ns/1ps
module sim_bch3_corrector;
  localparam int N = 15;
  localparam int LAT = 17;
  localparam logic [10:0] GEN = 11'h537;

  logic clk = 0, rst = 1, start = 0;
  logic [3:0] s1, s3, s5;
  logic [N-1:0] rxw;
  logic [N-1:0] corr, mask;
  logic done;
  int errors = 0, checks = 0;
  logic [3:0] alpha_exp [0:14];
  logic [N-1:0] got_corr, got_mask;
  int got_lat;

  always #4 clk = ~clk;

  bch3_corrector u0 (
    .clk(clk), .rst(rst), .start(start),
    .syn1_i(s1), .syn3_i(s3), .syn5_i(s5), .rx_word_i(rxw),
    .corr_word_o(corr), .err_mask_o(mask), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] encode(input logic [4:0] msg);
    logic [N-1:0] r;
    r = {msg, 10'b0};
    for (int b = N - 1; b >= 10; b--) if (r[b]) r = r ^ (N'(GEN) << (b - 10));
    return {msg, r[9:0]};
  endfunction

  function automatic logic [3:0] syn(input logic [N-1:0] w, input int i);
    logic [3:0] acc;
    acc = '0;
    for (int j = 0; j < N; j++) if (w[j]) acc = acc ^ alpha_exp[(i * j) % N];
    return acc;
  endfunction

  task automatic launch(input logic [N-1:0] w);
    @(negedge clk);
    rxw = w; s1 = syn(w, 1); s3 = syn(w, 3); s5 = syn(w, 5);
    start = 1;
    @(posedge clk); #1 start = 0;
  endtask

  task automatic wait_done;
    got_lat = 0;
    while (!done && got_lat < 40) begin
      @(posedge clk); #1 got_lat++;
    end
    got_corr = corr; got_mask = mask;
  endtask

  task automatic run(input logic [N-1:0] cw, input logic [N-1:0] err);
    string tag;
    int w;
    w = $countones(err);
    tag = (w == 0) ? "R3" : (w == 1) ? "R4" : (w == 2) ? "R5" : "R6";
    launch(cw ^ err);
    wait_done();
    check(got_corr == cw, tag, got_corr, cw);
    check(got_mask == err, {tag, "/R7 mask"}, got_mask, err);
    check(got_lat == LAT, "R8 latency", N'(got_lat), N'(LAT));
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    alpha_exp[0] = 4'd1;
    for (int k = 1; k < N; k++)
      alpha_exp[k] = alpha_exp[k-1][3] ? ((alpha_exp[k-1] << 1) ^ 4'b0011) : (alpha_exp[k-1] << 1);
    s1 = 0; s3 = 0; s5 = 0; rxw = 0;
    repeat (4) @(posedge clk);
    #1;
    check(!done && corr == '0 && mask == '0, "R1 reset", corr, '0);
    @(negedge clk) rst = 0;
    @(posedge clk); #1;
    check(!done && corr == '0 && mask == '0, "R1 after reset", mask, '0);

    // weight 0 and 1 on all codewords (R3, R4)
    for (int m = 0; m < 32; m++) begin
      run(encode(5'(m)), '0);
      for (int a = 0; a < N; a++) run(encode(5'(m)), N'(1) << a);
    end

    // weight 2 and 3 exhaustive on several codewords (R5, R6)
    for (int c = 0; c < 4; c++) begin
      logic [N-1:0] cw;
      cw = encode(5'(c * 9 + 3));
      for (int a = 0; a < N; a++)
        for (int b = a + 1; b < N; b++) begin
          run(cw, (N'(1) << a) | (N'(1) << b));
          for (int d = b + 1; d < N; d++)
            run(cw, (N'(1) << a) | (N'(1) << b) | (N'(1) << d));
        end
    end

    // R2: start during a decode is ignored
    begin
      logic [N-1:0] cw, e1;
      cw = encode(5'b10011);
      e1 = 15'h0421;
      launch(cw ^ e1);
      repeat (4) @(posedge clk);
      @(negedge clk);
      rxw = 15'h7fff; s1 = syn(rxw, 1); s3 = syn(rxw, 3); s5 = syn(rxw, 5);
      start = 1;
      @(posedge clk); #1 start = 0;
      wait_done();
      check(got_corr == cw, "R2 busy start ignored", got_corr, cw);
      check(got_lat == LAT - 5, "R2 timing unchanged", N'(got_lat), N'(LAT - 5));
      // R10: outputs hold after the pulse
      repeat (6) @(posedge clk);
      #1;
      check(corr == cw && mask == e1 && !done, "R10 hold", corr, cw);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule